// File: doc/BRIEF.md
# Transducer Frequency Sweep Sequencer

This block runs a stepped frequency scan of an ultrasonic transmitter. It walks the half period of a continuous drive waveform, counted in system clock cycles, upward from a start value to an end value. At each step it holds the waveform generator at the new half period and lets the transducer settle for a programmed number of cycles. It then takes a fixed block of converter samples and sends them out as one framed record.

Each record is a marker word of all ones, then the half period, then the samples. The record stream uses a valid/ready handshake. A sample FIFO at least one record deep absorbs back-pressure, so a slow consumer never causes a lost sample. The converter is external and paces the samples itself, typically one every 52 cycles (13 converter clocks at a quarter of the system clock).

After a one-cycle start pulse the whole sweep runs on its own. A one-cycle done pulse marks the end.

Top module: `sweep_seq`

## Requirements
- R1: After start, `gen_half_o` takes every value from the start half period to the end half period inclusive, in ascending order and one step at a time. `gen_run_o` is high from the first settle until the last record completes, and the end value may be the largest value that fits in `HALF_W` bits without wrapping.
- R2: For each half period exactly `SAMPLES` samples are recorded, in arrival order. Each is zero-extended to `DATA_W` bits.
- R3: Each record begins with a word of all ones, followed by the half period zero-extended to `DATA_W` bits, followed by the samples.
- R4: After each new half period is applied, the block stays in a settle phase for `settle_i`+1 cycles. During that phase no record word is offered and arriving samples are discarded.
- R5: A sample is taken only when `smp_valid_i` is high in the capture phase and fewer than `SAMPLES` samples have been taken for the current step. Any further samples are dropped.
- R6: While `rec_valid_o` is high and `rec_ready_i` is low, `rec_valid_o` and `rec_data_o` hold. Samples arriving during a stall are kept, not lost.
- R7: If the start value exceeds the end value, `done_o` is high in the cycle after the start pulse, no record word is offered, and `gen_run_o` stays low.
- R8: `done_o` is a single-cycle pulse in the cycle after the handshake of the final sample of the last record.
- R9: A start pulse while a sweep is active is ignored. The running sweep is unaffected.
- R10: Out of reset, `gen_run_o`, `rec_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| lo_half_i | input | HALF_W | First half period of the sweep |
| hi_half_i | input | HALF_W | Last half period of the sweep |
| settle_i | input | SETTLE_W | Settle cycles per step, minus one |
| smp_valid_i | input | 1 | Converter sample strobe |
| smp_data_i | input | SMP_W | Converter sample value |
| rec_ready_i | input | 1 | Record stream consumer ready |
| gen_half_o | output | HALF_W | Half period for the waveform generator |
| gen_run_o | output | 1 | Waveform generator enable |
| rec_valid_o | output | 1 | Record word valid |
| rec_data_o | output | DATA_W | Record word |
| done_o | output | 1 | Sweep complete pulse |

## Verification
A behavioural model using a sample queue predicts every output on every cycle. It is driven through five sweeps:
- A three-step sweep with a free consumer and sparse samples checks framing and step order.
- A single step with zero settle, samples on every cycle and a pseudo-random ready checks the drop rule past the sample limit and the hold-under-stall rule. A stray start during this sweep shows that restarts are ignored.
- A reversed range separates the empty-sweep path from a normal finish.
- A sweep with long ready-low bursts fills the buffer to a full record.
- A sweep ending at the all-ones half period catches any wrap in the step counter.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_CAPT   = 2'd2
   } sweep_st_t;

   typedef enum logic [1:0] {
      OP_MARK = 2'd0,
      OP_HALF = 2'd1,
      OP_BODY = 2'd2
   } out_ph_t;
endpackage

// File: rtl/sweep_fifo.sv
module sweep_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 1024
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         rd_i,
   output logic [W-1:0] rdata_o,
   output logic         empty_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_mod
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_i) mem[wp] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_i) wp <= wp_nx;
         if (rd_i) rp <= rp_nx;
         case ({wr_i, rd_i})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata_o = mem[rp];
   assign empty_o = (cnt == '0);

   // R6: a full buffer is never written without a read in the same cycle
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> (cnt < CW'(DEPTH)) || rd_i);
   // R6: the buffer is never read while empty
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |-> cnt != '0);
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
   import sweep_pkg::*;
#(
   parameter int HALF_W   = 16,
   parameter int SETTLE_W = 20,
   parameter int SAMPLES  = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [HALF_W-1:0]   lo_i,
   input  logic [HALF_W-1:0]   hi_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                smp_valid_i,
   input  logic                fire_i,
   output sweep_st_t           st_o,
   output out_ph_t             phase_o,
   output logic                wr_o,
   output logic [HALF_W-1:0]   cur_o,
   output logic                run_o,
   output logic                done_o
);
   localparam int CW = $clog2(SAMPLES + 1);

   sweep_st_t           st;
   out_ph_t             ph;
   logic [HALF_W-1:0]   cur, hi_q;
   logic [SETTLE_W-1:0] scnt;
   logic [CW-1:0]       cap, sent;
   logic                done_q;
   logic                last_word;

   assign wr_o      = (st == ST_CAPT) && smp_valid_i && (cap < CW'(SAMPLES));
   assign last_word = (ph == OP_BODY) && (sent == CW'(SAMPLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= OP_MARK;
         cur    <= '0;
         hi_q   <= '0;
         scnt   <= '0;
         cap    <= '0;
         sent   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (wr_o) cap <= cap + 1'b1;
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  if (lo_i > hi_i) begin
                     done_q <= 1'b1;
                  end else begin
                     st   <= ST_SETTLE;
                     cur  <= lo_i;
                     hi_q <= hi_i;
                     scnt <= settle_i;
                  end
               end
            end
            ST_SETTLE: begin
               if (scnt == '0) begin
                  st   <= ST_CAPT;
                  ph   <= OP_MARK;
                  cap  <= '0;
                  sent <= '0;
               end else begin
                  scnt <= scnt - 1'b1;
               end
            end
            ST_CAPT: begin
               if (fire_i) begin
                  case (ph)
                     OP_MARK: ph <= OP_HALF;
                     OP_HALF: ph <= OP_BODY;
                     default: begin
                        if (last_word) begin
                           if (cur == hi_q) begin
                              st     <= ST_IDLE;
                              done_q <= 1'b1;
                           end else begin
                              cur  <= cur + 1'b1;
                              st   <= ST_SETTLE;
                              scnt <= settle_i;
                           end
                        end else begin
                           sent <= sent + 1'b1;
                        end
                     end
                  endcase
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign st_o    = st;
   assign phase_o = ph;
   assign cur_o   = cur;
   assign run_o   = (st != ST_IDLE);
   assign done_o  = done_q;

   // R8: done lasts a single cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R1: the applied half period never passes the end value
   p_half_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> cur_o <= hi_q);
   // R1: during a sweep the half period only moves up by one
   p_half_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && $past(run_o) && (cur_o != $past(cur_o))) |-> cur_o == $past(cur_o) + 1'b1);
endmodule

// File: rtl/sweep_framer.sv
module sweep_framer
   import sweep_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int SMP_W  = 10,
   parameter int DATA_W = 16
) (
   input  sweep_st_t          st_i,
   input  out_ph_t            phase_i,
   input  logic [HALF_W-1:0]  cur_i,
   input  logic [SMP_W-1:0]   head_i,
   input  logic               empty_i,
   input  logic               ready_i,
   output logic               valid_o,
   output logic [DATA_W-1:0]  data_o,
   output logic               pop_o,
   output logic               fire_o
);
   always_comb begin
      valid_o = 1'b0;
      data_o  = '0;
      if (st_i == ST_CAPT) begin
         case (phase_i)
            OP_MARK: begin
               valid_o = 1'b1;
               data_o  = '1;
            end
            OP_HALF: begin
               valid_o = 1'b1;
               data_o  = DATA_W'(cur_i);
            end
            default: begin
               valid_o = !empty_i;
               data_o  = DATA_W'(head_i);
            end
         endcase
      end
   end

   assign fire_o = valid_o && ready_i;
   assign pop_o  = fire_o && (phase_i == OP_BODY);
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
   import sweep_pkg::*;
#(
   parameter int HALF_W   = 16,
   parameter int SMP_W    = 10,
   parameter int DATA_W   = 16,
   parameter int SETTLE_W = 20,
   parameter int SAMPLES  = 1024,
   parameter int DEPTH    = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [HALF_W-1:0]   lo_half_i,
   input  logic [HALF_W-1:0]   hi_half_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                smp_valid_i,
   input  logic [SMP_W-1:0]    smp_data_i,
   input  logic                rec_ready_i,
   output logic [HALF_W-1:0]   gen_half_o,
   output logic                gen_run_o,
   output logic                rec_valid_o,
   output logic [DATA_W-1:0]   rec_data_o,
   output logic                done_o
);
   generate
      if (DEPTH < SAMPLES) begin : g_bad_depth
         $error("sweep_seq: DEPTH must hold one full record of samples");
      end
      if (DEPTH < 2) begin : g_bad_min
         $error("sweep_seq: DEPTH must be at least 2");
      end
      if (DATA_W < HALF_W || DATA_W < SMP_W) begin : g_bad_width
         $error("sweep_seq: DATA_W narrower than a half period or a sample");
      end
   endgenerate

   sweep_st_t        st;
   out_ph_t          ph;
   logic             wr, pop, fire, empty;
   logic [SMP_W-1:0] head;

   sweep_ctrl #(.HALF_W(HALF_W), .SETTLE_W(SETTLE_W), .SAMPLES(SAMPLES)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lo_i(lo_half_i), .hi_i(hi_half_i),
      .settle_i(settle_i), .smp_valid_i(smp_valid_i), .fire_i(fire), .st_o(st),
      .phase_o(ph), .wr_o(wr), .cur_o(gen_half_o), .run_o(gen_run_o), .done_o(done_o)
   );

   sweep_fifo #(.W(SMP_W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .wdata_i(smp_data_i), .rd_i(pop),
      .rdata_o(head), .empty_o(empty)
   );

   sweep_framer #(.HALF_W(HALF_W), .SMP_W(SMP_W), .DATA_W(DATA_W)) i_framer (
      .st_i(st), .phase_i(ph), .cur_i(gen_half_o), .head_i(head), .empty_i(empty),
      .ready_i(rec_ready_i), .valid_o(rec_valid_o), .data_o(rec_data_o),
      .pop_o(pop), .fire_o(fire)
   );

   // R6: a stalled word holds until it is taken
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && !rec_ready_i) |=> rec_valid_o && $stable(rec_data_o));
   // R7: no record word appears without the drive running
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_run_o |-> !rec_valid_o);
endmodule

// File: tb/test_sweep_seq.sv
module test_sweep_seq;
   localparam int HW = 16, SW = 10, DW = 16, TW = 8, NS = 8, DP = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [HW-1:0] lo_half_i = '0, hi_half_i = '0;
   logic [TW-1:0] settle_i = '0;
   logic          smp_valid_i = 1'b0;
   logic [SW-1:0] smp_data_i = '0;
   logic          rec_ready_i = 1'b0;
   logic [HW-1:0] gen_half_o;
   logic          gen_run_o, rec_valid_o, done_o;
   logic [DW-1:0] rec_data_o;

   int total = 0, bad = 0, cyc = 0;
   int smp_per = 4, rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit finished = 0;

   always #10 clk = ~clk;

   sweep_seq #(.HALF_W(HW), .SMP_W(SW), .DATA_W(DW), .SETTLE_W(TW),
               .SAMPLES(NS), .DEPTH(DP)) i_sweep_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lo_half_i(lo_half_i),
      .hi_half_i(hi_half_i), .settle_i(settle_i), .smp_valid_i(smp_valid_i),
      .smp_data_i(smp_data_i), .rec_ready_i(rec_ready_i), .gen_half_o(gen_half_o),
      .gen_run_o(gen_run_o), .rec_valid_o(rec_valid_o), .rec_data_o(rec_data_o),
      .done_o(done_o)
   );

   // reference model state
   int          ms = 0, mph = 0, mcnt = 0, mcap = 0, msent = 0;
   int unsigned mcur = 0, mhi = 0;
   bit          mdone = 0;
   logic [SW-1:0] mq[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      bit ev, fire;
      cyc++;
      if (!rst_n) begin
         ms = 0; mph = 0; mcnt = 0; mcap = 0; msent = 0; mcur = 0; mhi = 0; mdone = 0;
         mq.delete();
      end else begin
         ev = (ms == 2) && (mph != 2 || mq.size() > 0);
         fire = ev && rec_ready_i;
         mdone = 0;
         if (ms == 2 && fire && mph == 2) void'(mq.pop_front());
         if (ms == 2 && smp_valid_i && mcap < NS) begin
            mq.push_back(smp_data_i);
            mcap++;
         end
         if (ms == 0) begin
            if (start_i) begin
               if (lo_half_i > hi_half_i) mdone = 1;
               else begin ms = 1; mcur = lo_half_i; mhi = hi_half_i; mcnt = settle_i; end
            end
         end else if (ms == 1) begin
            if (mcnt == 0) begin ms = 2; mph = 0; mcap = 0; msent = 0; end
            else mcnt--;
         end else if (fire) begin
            if (mph < 2) mph++;
            else if (msent == NS - 1) begin
               if (mcur == mhi) begin ms = 0; mdone = 1; end
               else begin mcur++; ms = 1; mcnt = settle_i; end
            end else msent++;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      bit ev;
      logic [DW-1:0] ed;
      if (rst_n && !finished) begin
         ev = (ms == 2) && (mph != 2 || mq.size() > 0);
         ed = (mph == 0) ? '1 : (mph == 1) ? DW'(mcur) : ((mq.size() > 0) ? DW'(mq[0]) : '0);
         chk(gen_run_o == (ms != 0), "R1 run", gen_run_o, ms != 0);
         if (ms != 0) chk(gen_half_o == HW'(mcur), "R1 half", gen_half_o, mcur);
         chk(rec_valid_o == ev, (ms == 1) ? "R4 settle" : "R6 valid", rec_valid_o, ev);
         if (ev && rec_valid_o)
            chk(rec_data_o == ed, (mph < 2) ? "R3 header" : "R2,R5 sample", rec_data_o, ed);
         chk(done_o == mdone, "R8 done", done_o, mdone);
      end
   end

   // sample and ready generators
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_valid_i <= (cyc % smp_per) == 0;
      if ((cyc % smp_per) == 0) smp_data_i <= smp_data_i + 10'd37;
      case (rdy_mode)
         0: rec_ready_i <= 1'b1;
         1: rec_ready_i <= lfsr[0];
         default: rec_ready_i <= (cyc % 60) > 45;
      endcase
   end

   task automatic finish_up();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic sweep(input int lo, input int hi, input int st, input bit stray);
      lo_half_i = HW'(lo); hi_half_i = HW'(hi); settle_i = TW'(st);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (stray) begin
         repeat (3) @(negedge clk);
         lo_half_i = HW'(lo + 30);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
         @(negedge clk);
         // R9: stray start must not disturb the running sweep
         chk(gen_half_o == HW'(lo) && gen_run_o, "R9 restart ignored", gen_half_o, lo);
         lo_half_i = HW'(lo);
      end
      while (!done_o) @(negedge clk);
      chk(gen_half_o == HW'(hi), "R1 last half", gen_half_o, hi);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      chk(!gen_run_o && !rec_valid_o && !done_o, "R10 reset",
          {gen_run_o, rec_valid_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      smp_per = 4;  rdy_mode = 0; sweep(5, 7, 10, 0);
      smp_per = 1;  rdy_mode = 1; sweep(20, 20, 0, 1);
      // R7: reversed range ends at once with nothing sent
      lo_half_i = 16'd9; hi_half_i = 16'd3;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(done_o == 1'b1, "R7 done", done_o, 1);
      chk(!gen_run_o && !rec_valid_o, "R7 quiet", {gen_run_o, rec_valid_o}, 0);
      repeat (4) @(negedge clk);
      smp_per = 2;  rdy_mode = 2; sweep(100, 102, 3, 0);
      smp_per = 3;  rdy_mode = 1; sweep(16'hFFFE, 16'hFFFF, 1, 0);
      finish_up();
   end
endmodule